// File: doc/BRIEF.md
# Parallel NOR Flash Read-Path Emulator

This block is a synthesizable device-side stand-in for a parallel NOR flash. It lets a memory controller under test be exercised without a real part. The controller drives chip enable, address-valid and write enable (all active low), an address bus and a 16-bit data bus. The block tracks which of four read states is current: array, identifier, status or query. It answers with array contents, identifier words, a status word or query-table words. Program and erase are not modelled. A write cycle only selects the read state, sets the ready bit in status or loads the read configuration.

Two read modes exist. Page mode is the default. On an address latch, a 16-word page is copied into a buffer, and the low four address bits select the returned word combinationally. The clock does not advance data in this mode and wait stays low. When the configuration selects synchronous mode, each latch starts a burst. Wait is held high for a programmable latency. After that, one word is presented per clock edge: consecutive array words, or one repeated word for the non-array states.

All bus inputs are sampled on `clk_i`. `rst_ni` plays the part of the device reset pin.

Top module: `nor_rd_emu`

## Requirements
- R1: After `rst_ni` is released, the block is in the array read state and in page mode.
- R2: A write cycle is one clock edge where `ce_ni` and `we_ni` are low and `we_ni` was high at the edge before. Its data selects the read state as follows:
  - 0x00FF selects array.
  - 0x0090 selects identifier.
  - 0x0070 selects status.
  - 0x0098 selects query.
  - Any other value selects status, including both words of the configuration sequence. After it, array data returns only after 0x00FF.
- R3: The status word reads 0x0080 after any write cycle, whatever the address.
- R4: Page-mode array reads work as follows:
  - An address latch copies the 16 words that share address bits [15:4].
  - `addr_i[3:0]` then selects the word. Upper address bits changed after the latch are ignored.
  - Output does not change across clock edges while the address is steady, and `wait_o` stays low.
  - The array word at address a is {a[7:0], a[15:8]} XOR 0x5AC3.
  - A latch is the first edge with `ce_ni` low, `adv_ni` low and `we_ni` high after an edge where `ce_ni` or `adv_ni` was high.
- R5: Non-array words depend on the address low byte:
  - Identifier: 0x00 gives 0x00C5, 0x01 gives 0x2218, any other value gives 0.
  - Query: 0x10, 0x11 and 0x12 give 0x0051, 0x0052 and 0x0059, any other value gives 0.
- R6: Writing 0x0060 then 0x0003 loads the configuration from the address of the second write:
  - Bit 15 = 0 selects synchronous mode.
  - Bits [13:11] hold the latency.
  - Bits [1:0] hold the burst length: 0 = 4, 1 = 8, 2 = 16, 3 = continuous.
  - Any other word after 0x0060 leaves the configuration unchanged.
- R7: `rst_ni` low restores the configuration to page mode.
- R8: In synchronous mode, `wait_o` is high and `dq_oe_o` is low from the latch edge until L edges after it. The first word appears at that edge, where L is the latency field and 0 or 1 count as 1.
- R9: In synchronous array state, each later edge advances the address by one. For fixed lengths the address wraps inside the length-aligned block; for continuous length it runs linearly.
- R10: In synchronous non-array states, the word for the latched address repeats on every edge.
- R11: With `ce_ni` high, `dq_oe_o` and `wait_o` are low and any burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and burst clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| adv_ni | input | 1 | Address valid, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 16 | Word address |
| dq_i | input | 16 | Command or data written by the controller |
| dq_o | output | 16 | Read data |
| dq_oe_o | output | 1 | Read data drive enable |
| wait_o | output | 1 | Burst data not yet valid |

## Verification
The hardest situation to reach is a synchronous burst in the intended state. It needs the two-write configuration sequence, then a read-state command, then a fresh address latch, all without a reset in between. A reset would silently drop the block back to page mode. The stimulus chains these writes and then counts edges from the latch, sampling wait and data at each one. This covers wrap-around at the four-word and eight-word block ends, a continuous run across a 16-word boundary, and the repeated identifier word. A cancelled configuration sequence is caught by observing that wait still rises on the next latch.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int PAGE_W = 4;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int LAT_W  = 3;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_IDENT  = 2'd1,
    RS_STATUS = 2'd2,
    RS_QUERY  = 2'd3
  } rd_state_e;

  typedef struct packed {
    logic             async_md;
    logic [LAT_W-1:0] lat;
    logic [1:0]       len;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{async_md: 1'b1, lat: '0, len: 2'd0};

  localparam logic [DATA_W-1:0] C_ARRAY  = 16'h00FF;
  localparam logic [DATA_W-1:0] C_IDENT  = 16'h0090;
  localparam logic [DATA_W-1:0] C_STATUS = 16'h0070;
  localparam logic [DATA_W-1:0] C_QUERY  = 16'h0098;
  localparam logic [DATA_W-1:0] C_CFG1   = 16'h0060;
  localparam logic [DATA_W-1:0] C_CFG2   = 16'h0003;

  function automatic logic [DATA_W-1:0] arr_word(input logic [ADDR_W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5AC3;
  endfunction

  function automatic logic [DATA_W-1:0] qry_word(input logic [7:0] a);
    case (a)
      8'h10:   return 16'h0051;
      8'h11:   return 16'h0052;
      8'h12:   return 16'h0059;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nor_cmd_dec.sv
module nor_cmd_dec
  import nor_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  cfg_t              cfg_val_i,
  output rd_state_e         state_o,
  output cfg_t              cfg_o,
  output logic              ready_o
);
  logic cfg_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o    <= RS_ARRAY;
      cfg_o      <= CFG_DEF;
      ready_o    <= 1'b0;
      cfg_pend_q <= 1'b0;
    end else if (wr_i) begin
      ready_o    <= 1'b1;
      cfg_pend_q <= 1'b0;
      if (cfg_pend_q) begin
        // second word of config sequence; anything else cancels
        if (data_i == C_CFG2) cfg_o <= cfg_val_i;
        state_o <= RS_STATUS;
      end else begin
        case (data_i)
          C_ARRAY:  state_o <= RS_ARRAY;
          C_IDENT:  state_o <= RS_IDENT;
          C_STATUS: state_o <= RS_STATUS;
          C_QUERY:  state_o <= RS_QUERY;
          C_CFG1: begin
            state_o    <= RS_STATUS;
            cfg_pend_q <= 1'b1;
          end
          default:  state_o <= RS_STATUS;
        endcase
      end
    end
  end

  // R2
  ff_to_array_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cfg_pend_q && data_i == C_ARRAY) |=> state_o == RS_ARRAY);

  // R3
  sr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ready_o);
endmodule

// File: rtl/nor_page_buf.sv
module nor_page_buf
  import nor_rd_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i,
  input  logic [PAGE_W-1:0]        sel_i,
  output logic [DATA_W-1:0]        word_o
);
  logic [DATA_W-1:0] page_q [PAGE_N];

  for (genvar i = 0; i < PAGE_N; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     page_q[i] <= '0;
      else if (load_i) page_q[i] <= arr_word({base_i, PAGE_W'(i)});
    end
  end

  assign word_o = page_q[sel_i];
endmodule

// File: rtl/nor_burst_ctrl.sv
module nor_burst_ctrl
  import nor_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              latch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [1:0]        len_i,
  output logic              active_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [LAT_W-1:0]  lat_cnt_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] wrap_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o  <= 1'b0;
      valid_o   <= 1'b0;
      lat_cnt_q <= '0;
      cnt_q     <= '0;
      start_o   <= '0;
    end else if (ce_ni) begin
      active_o <= 1'b0;
      valid_o  <= 1'b0;
    end else if (latch_i) begin
      active_o  <= 1'b1;
      valid_o   <= 1'b0;
      lat_cnt_q <= (lat_i < LAT_W'(2)) ? LAT_W'(1) : lat_i;
      cnt_q     <= '0;
      start_o   <= addr_i;
    end else if (active_o && !valid_o) begin
      if (lat_cnt_q <= LAT_W'(1)) valid_o <= 1'b1;
      else lat_cnt_q <= lat_cnt_q - LAT_W'(1);
    end else if (valid_o) begin
      cnt_q <= cnt_q + ADDR_W'(1);
    end
  end

  always_comb begin
    case (len_i)
      2'd0:    wrap_mask = ADDR_W'(3);
      2'd1:    wrap_mask = ADDR_W'(7);
      2'd2:    wrap_mask = ADDR_W'(15);
      default: wrap_mask = '1;
    endcase
  end

  assign addr_o = (start_o & ~wrap_mask) | ((start_o + cnt_q) & wrap_mask);

  // R8
  no_early_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> !valid_o);
endmodule

// File: rtl/nor_rd_emu.sv
module nor_rd_emu
  import nor_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              wait_o
);
  localparam logic [DATA_W-1:0] MFR_WORD = 16'h00C5;
  localparam logic [DATA_W-1:0] DEV_WORD = 16'h2218;

  logic      we_q, armed_q, wr, latch, ready, sync_en;
  logic      b_active, b_valid;
  rd_state_e state;
  cfg_t      cfg, cfg_val;
  logic [DATA_W-1:0] page_word, sr_word;
  logic [ADDR_W-1:0] b_start, b_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      we_q    <= we_ni;
      armed_q <= ce_ni | adv_ni;
    end
  end

  assign wr      = !ce_ni && !we_ni && we_q;
  assign latch   = !ce_ni && !adv_ni && we_ni && armed_q;
  assign cfg_val = '{async_md: addr_i[15], lat: addr_i[13:11], len: addr_i[1:0]};
  assign sr_word = {8'h00, ready, 7'h00};

  nor_cmd_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .data_i    (dq_i),
    .cfg_val_i (cfg_val),
    .state_o   (state),
    .cfg_o     (cfg),
    .ready_o   (ready)
  );

  nor_page_buf u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (latch),
    .base_i (addr_i[ADDR_W-1:PAGE_W]),
    .sel_i  (addr_i[PAGE_W-1:0]),
    .word_o (page_word)
  );

  nor_burst_ctrl u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .latch_i  (latch),
    .addr_i   (addr_i),
    .lat_i    (cfg.lat),
    .len_i    (cfg.len),
    .active_o (b_active),
    .valid_o  (b_valid),
    .start_o  (b_start),
    .addr_o   (b_addr)
  );

  assign sync_en = !cfg.async_md;

  function automatic logic [DATA_W-1:0] nonarr(input rd_state_e s,
                                               input logic [7:0] a,
                                               input logic [DATA_W-1:0] sr);
    case (s)
      RS_IDENT:  return (a == 8'h00) ? MFR_WORD : (a == 8'h01) ? DEV_WORD : '0;
      RS_QUERY:  return qry_word(a);
      default:   return sr;
    endcase
  endfunction

  always_comb begin
    if (sync_en)
      dq_o = (state == RS_ARRAY) ? arr_word(b_addr) : nonarr(state, b_start[7:0], sr_word);
    else
      dq_o = (state == RS_ARRAY) ? page_word : nonarr(state, addr_i[7:0], sr_word);
  end

  assign dq_oe_o = !ce_ni && we_ni && (sync_en ? b_valid : 1'b1);
  assign wait_o  = !ce_ni && sync_en && b_active && !b_valid;

  // R4
  async_no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.async_md |-> !wait_o);

  // R11
  ce_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> (!dq_oe_o && !wait_o));

  // R10
  nonarray_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en && b_valid && $past(b_valid) && state != RS_ARRAY &&
     $stable(state) && $stable(ready) && $stable(cfg)) |-> $stable(dq_o));
endmodule

// File: tb/nor_rd_emu_test.sv
module nor_rd_emu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, adv_ni = 1'b1, we_ni = 1'b1;
  logic [15:0] addr_i = '0, dq_i = '0;
  logic [15:0] dq_o;
  logic        dq_oe_o, wait_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  nor_rd_emu uut (.*);

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] addr;
    logic [15:0] exp;
    logic        arr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h00FF, 16'h0000, 16'h0000, 1'b1},   // R2 R4
    '{16'h00FF, 16'h1237, 16'h0000, 1'b1},
    '{16'h00FF, 16'hFFFF, 16'h0000, 1'b1},
    '{16'h0090, 16'h0000, 16'h00C5, 1'b0},   // R5
    '{16'h0090, 16'h0001, 16'h2218, 1'b0},
    '{16'h0090, 16'h0002, 16'h0000, 1'b0},
    '{16'h0098, 16'h0010, 16'h0051, 1'b0},
    '{16'h0098, 16'h0011, 16'h0052, 1'b0},
    '{16'h0098, 16'h0012, 16'h0059, 1'b0},
    '{16'h0098, 16'h0013, 16'h0000, 1'b0},
    '{16'h0070, 16'h4444, 16'h0080, 1'b0},   // R3
    '{16'h0040, 16'h0003, 16'h0080, 1'b0},   // R2 unknown -> status
    '{16'h00FF, 16'h8009, 16'h0000, 1'b1}
  };

  function automatic logic [15:0] arr_exp(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5AC3;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] cmd, input logic [15:0] a);
    @(negedge clk_i);
    ce_ni = 1'b0; we_ni = 1'b0; adv_ni = 1'b1; dq_i = cmd; addr_i = a;
    @(negedge clk_i);
    ce_ni = 1'b1; we_ni = 1'b1;
  endtask

  // returns at the negedge after the latch edge, ce still low
  task automatic latch(input logic [15:0] a);
    @(negedge clk_i);
    ce_ni = 1'b0; adv_ni = 1'b0; addr_i = a;
    @(negedge clk_i);
    adv_ni = 1'b1;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    ce_ni = 1'b1; adv_ni = 1'b1;
    #1;
  endtask

  task automatic cfg_wr(input logic [15:0] v);
    wr(16'h0060, 16'h0000);
    wr(16'h0003, v);
  endtask

  // checks wait for lat edges from latch, then nw words
  task automatic burst(input string req, input int lat, input logic [15:0] a,
                       input logic arr, input logic [15:0] fixed, input int nw,
                       input logic [15:0] mask);
    latch(a);
    for (int j = 0; j < lat; j++) begin
      if (j > 0) begin @(negedge clk_i); #1; end
      chk("R8 wait", {15'h0, wait_o}, 16'h1);
      chk("R8 oe", {15'h0, dq_oe_o}, 16'h0);
    end
    for (int w = 0; w < nw; w++) begin
      @(negedge clk_i); #1;
      chk("R8 oe", {15'h0, dq_oe_o}, 16'h1);
      chk(req, dq_o, arr ? arr_exp((a & ~mask) | ((a + 16'(w)) & mask)) : fixed);
    end
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: array state and page mode straight out of reset
    latch(16'h0042);
    chk("R1 data", dq_o, arr_exp(16'h0042));
    chk("R1 wait", {15'h0, wait_o}, 16'h0);
    chk("R1 oe", {15'h0, dq_oe_o}, 16'h1);
    idle();
    // R11
    chk("R11 oe", {15'h0, dq_oe_o}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].cmd, 16'h0000);
      latch(VECS[i].addr);
      chk("R2/R5 table", dq_o, VECS[i].arr ? arr_exp(VECS[i].addr) : VECS[i].exp);
      chk("R4 wait", {15'h0, wait_o}, 16'h0);
      idle();
    end

    // R4: low bits select, upper bits after latch ignored, clock ignored
    wr(16'h00FF, 16'h0000);
    latch(16'h0230);
    addr_i = 16'h5534; #1;
    chk("R4 page sel", dq_o, arr_exp(16'h0234));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); #1;
      chk("R4 stable", dq_o, arr_exp(16'h0234));
    end
    addr_i = 16'h553F; #1;
    chk("R4 page end", dq_o, arr_exp(16'h023F));
    idle();

    // R2: array not returned after a non-read write until 0xFF
    wr(16'h0040, 16'h0000);
    latch(16'h0230);
    chk("R2 status after write", dq_o, 16'h0080);
    idle();

    // R6 R8 R9: latency 3, length 4 wrap
    cfg_wr(16'h1800);
    wr(16'h00FF, 16'h0000);
    burst("R9 wrap4", 3, 16'h0106, 1'b1, 16'h0, 5, 16'h0003);

    // R10: identifier word repeats
    wr(16'h0090, 16'h0000);
    burst("R10 ident repeat", 3, 16'h0001, 1'b0, 16'h2218, 4, 16'h0003);
    wr(16'h0098, 16'h0000);
    burst("R10 query repeat", 3, 16'h0012, 1'b0, 16'h0059, 3, 16'h0003);

    // R9: continuous length, latency 2, crossing 16-word boundary
    cfg_wr(16'h1003);
    wr(16'h00FF, 16'h0000);
    burst("R9 continuous", 2, 16'h00FE, 1'b1, 16'h0, 4, 16'hFFFF);

    // R8 R9: latency 0 counts as 1, length 8 wrap
    cfg_wr(16'h0001);
    wr(16'h00FF, 16'h0000);
    burst("R9 wrap8", 1, 16'h0007, 1'b1, 16'h0, 3, 16'h0007);

    // R6: cancelled sequence keeps synchronous config
    wr(16'h0060, 16'h0000);
    wr(16'h0020, 16'h8000);
    wr(16'h00FF, 16'h0000);
    latch(16'h0010);
    chk("R6 cancel keeps sync", {15'h0, wait_o}, 16'h1);
    // R11: ce high ends burst
    idle();
    chk("R11 wait", {15'h0, wait_o}, 16'h0);
    chk("R11 oe", {15'h0, dq_oe_o}, 16'h0);

    // R7: reset returns to page mode
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    latch(16'h0091);
    chk("R7 page after reset", dq_o, arr_exp(16'h0091));
    chk("R7 wait", {15'h0, wait_o}, 16'h0);
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule